// File: doc/BRIEF.md
# Crosspoint Routing Configurator with Shadow and Live Banks

This block is the digital control front end of a 16-input, 8-output analog routing matrix. Every matrix output has a live entry: an enable bit and a 4-bit input index. The live entries drive the matrix directly. Software never writes them. It loads a second, shadow bank through a serial port with a serial clock, data in, data out and an active-low select. A separate configure strobe then copies the whole shadow bank into the live bank in one cycle. The strobe works whether or not the select is asserted, so several configurators sharing a bus can be loaded one after another and then switched together.

The serial port has two frame formats, chosen by a mode input. In chain mode, one 40-bit stream rewrites every shadow entry, and the bit pushed out of the far end of the chain appears on the data-out pin so that devices can be cascaded. In addressed mode, an 8-bit frame names one output and rewrites only that shadow entry. The serial pins are sampled in the block's own clock domain. They are assumed to be synchronized upstream, and the serial clock runs at a quarter of the system clock rate or slower.

After the select falls, the first rising serial-clock edge opens the frame. Bits are taken on falling serial-clock edges. A frame closes at the first rising serial-clock edge that arrives while the select is high.

Top module: `xpt_serial_cfg`

## Requirements
- R1: After reset, every output is disabled with input index 0, and data-out is 0.
- R2: In chain mode (mode = 0), a 40-bit frame is sent most significant bit first, beginning with output 7. Each output takes 5 bits: its enable bit, then its 4-bit input index. Output k therefore holds chain bits [5k+4] (enable) and [5k+3:5k] (index). After a configure strobe, the outputs show the frame.
- R3: Loading the shadow bank never changes the live outputs. They change only at a rising edge of the configure input.
- R4: While the select is high, serial-clock and data activity shifts nothing and changes neither the shadow bank nor data-out.
- R5: A falling serial-clock edge that comes after the select falls but before the first rising edge takes no bit.
- R6: In addressed mode (mode = 1, latched when the frame opens), an 8-bit frame is sent most significant bit first. It carries a 3-bit output address, the enable bit and the 4-bit index. When the frame closes, only the addressed shadow entry is updated.
- R7: When an addressed-mode frame closes with a bit count other than 8, it is discarded.
- R8: A configure strobe with no shadow update since the previous copy leaves the outputs unchanged.
- R9: On each chain-mode shift, data-out takes the bit pushed out of chain bit 39. It changes only on falling serial-clock edges.
- R10: If a configure edge and a chain shift fall in the same cycle, the live bank takes the shadow contents from before the shift. The newly shifted bit stays pending and is copied by the next strobe.
- R11: A configure strobe takes effect while the select is low, in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdin | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| mode | input | 1 | 0 = chain frame, 1 = addressed frame |
| cfg | input | 1 | Configure strobe; a rising edge copies shadow to live |
| dout | output | 1 | Bit pushed out of the chain |
| out_en | output | 8 | Live enable bit per output |
| out_sel | output | 32 | Live 4-bit input index per output, output k at [4k+3:4k] |

## Verification
The configure copy and a chain shift can land on the same system clock edge. The bench provokes this by driving the configure strobe high in the same cycle that the serial clock falls on the 40th bit of a frame. It expects the outputs to show the 39-bit shadow state, not the 40-bit one. A second strobe must then reveal the completed frame, which proves the shifted bit was kept as pending. A reference model of the shadow and live banks predicts each outcome.

// File: rtl/xpt_serial_cfg.sv
module xpt_serial_cfg #(
  parameter int N_IN  = 16,
  parameter int N_OUT = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sclk,
  input  logic                             sdin,
  input  logic                             cs_n,
  input  logic                             mode,
  input  logic                             cfg,
  output logic                             dout,
  output logic [N_OUT-1:0]                 out_en,
  output logic [N_OUT*$clog2(N_IN)-1:0]    out_sel
);
  localparam int SEL_W   = $clog2(N_IN);
  localparam int ENT_W   = SEL_W + 1;
  localparam int CHAIN_W = N_OUT * ENT_W;
  localparam int AW      = $clog2(N_OUT);
  localparam int AFR_W   = AW + ENT_W;
  localparam int CNT_W   = $clog2(AFR_W + 2);

  logic               sclk_q, cfg_q, armed, fmode, pending, dout_q;
  logic [CNT_W-1:0]   cnt;
  logic [AFR_W-1:0]   asr;
  logic [CHAIN_W-1:0] shadow, active;

  wire s_rise   = sclk & ~sclk_q;
  wire s_fall   = ~sclk & sclk_q;
  wire c_rise   = cfg & ~cfg_q;
  wire shift_en = s_fall & armed & ~cs_n & ~fmode;
  wire acap_en  = s_fall & armed & ~cs_n & fmode;
  wire close    = s_rise & armed & cs_n;
  wire commit   = close & fmode & (cnt == CNT_W'(AFR_W));
  wire upd      = shift_en | commit;
  wire [AW-1:0]    a_addr = asr[AFR_W-1 -: AW];
  wire [ENT_W-1:0] a_ent  = asr[ENT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cfg_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cfg_q  <= cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      fmode <= 1'b0;
      cnt   <= '0;
      asr   <= '0;
    end else begin
      if (!armed && !cs_n && s_rise) begin
        armed <= 1'b1;
        fmode <= mode;
        cnt   <= '0;
      end else if (close) begin
        armed <= 1'b0;
      end
      if (acap_en) begin
        asr <= {asr[AFR_W-2:0], sdin};
        if (cnt != CNT_W'(AFR_W + 1)) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      dout_q <= 1'b0;
    end else if (shift_en) begin
      shadow <= {shadow[CHAIN_W-2:0], sdin};
      dout_q <= shadow[CHAIN_W-1];
    end else begin
      for (int k = 0; k < N_OUT; k++)
        if (commit && a_addr == AW'(k)) shadow[k*ENT_W +: ENT_W] <= a_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= '0;
      pending <= 1'b0;
    end else begin
      if (c_rise && pending) active <= shadow;
      pending <= upd | (pending & ~c_rise);
    end
  end

  assign dout = dout_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assign out_en[k]                  = active[k*ENT_W + SEL_W];
    assign out_sel[k*SEL_W +: SEL_W]  = active[k*ENT_W +: SEL_W];
  end

  a_r3_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rise |=> ($stable(out_en) && $stable(out_sel)));

  a_r8_no_new_data: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rise && !pending) |=> ($stable(out_en) && $stable(out_sel)));

  a_r4_cs_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !armed) |=> ($stable(shadow) && $stable(dout)));

  a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (close && fmode && cnt != CNT_W'(AFR_W)) |=> $stable(shadow));

  a_r9_dout_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !s_fall |=> $stable(dout));

  a_r10_keep_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rise && shift_en) |=> pending);
endmodule

// File: tb/xpt_serial_cfg_bench.sv
module xpt_serial_cfg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdin = 1'b0, cs_n = 1'b1, mode = 1'b0, cfg = 1'b0;
  logic dout;
  logic [7:0]  out_en;
  logic [31:0] out_sel;

  xpt_serial_cfg u_xpt_serial_cfg (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
    .cs_n(cs_n), .mode(mode), .cfg(cfg), .dout(dout), .out_en(out_en), .out_sel(out_sel));

  always #5 clk = ~clk;

  typedef struct { logic [7:0] en; logic [31:0] sel; logic d; string tag; } exp_t;
  exp_t q[$];
  int errs = 0, checks = 0;

  logic [39:0] m_sh = '0, m_act = '0;
  logic        m_pend = 1'b0, m_dout = 1'b0, cur_addr = 1'b0;
  logic [7:0]  abuf = '0;
  int          nbits = 0;

  task automatic expect_now(string tag);
    exp_t e;
    for (int k = 0; k < 8; k++) begin
      e.en[k] = m_act[5*k+4];
      e.sel[4*k +: 4] = m_act[5*k +: 4];
    end
    e.d = m_dout; e.tag = tag;
    q.push_back(e);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks += 3;
        if (out_en !== e.en) begin errs++;
          $display("FAIL %s out_en actual=%h expected=%h", e.tag, out_en, e.en); end
        if (out_sel !== e.sel) begin errs++;
          $display("FAIL %s out_sel actual=%h expected=%h", e.tag, out_sel, e.sel); end
        if (dout !== e.d) begin errs++;
          $display("FAIL %s dout actual=%b expected=%b", e.tag, dout, e.d); end
      end
    end
  end

  task automatic sbit(input logic b);
    sdin = b; sclk = 1'b1; repeat (2) @(negedge clk);
    sclk = 1'b0; repeat (2) @(negedge clk);
    if (!cur_addr) begin m_dout = m_sh[39]; m_sh = {m_sh[38:0], b}; m_pend = 1'b1; end
    else begin abuf = {abuf[6:0], b}; nbits++; end
  endtask

  task automatic open_frame(input logic md);
    mode = md; cs_n = 1'b0; repeat (2) @(negedge clk);
    cur_addr = md; nbits = 0;
  endtask

  task automatic close_frame();
    cs_n = 1'b1; repeat (2) @(negedge clk);
    sclk = 1'b1; repeat (2) @(negedge clk);
    sclk = 1'b0; repeat (2) @(negedge clk);
    if (cur_addr && nbits == 8) begin m_sh[5*abuf[7:5] +: 5] = abuf[4:0]; m_pend = 1'b1; end
  endtask

  task automatic pulse_cfg();
    cfg = 1'b1; @(negedge clk); cfg = 1'b0; @(negedge clk);
    if (m_pend) begin m_act = m_sh; m_pend = 1'b0; end
  endtask

  function automatic logic [39:0] make_frame(input int seed);
    logic [39:0] f;
    for (int k = 0; k < 8; k++) begin
      f[5*k+4]  = ((k + seed) % 3) != 0;
      f[5*k +: 4] = 4'((k * 5 + seed) % 16);
    end
    return f;
  endfunction

  task automatic send_chain(input logic [39:0] f);
    open_frame(1'b0);
    for (int i = 39; i >= 0; i--) sbit(f[i]);
    close_frame();
  endtask

  task automatic send_addr(input logic [2:0] a, input logic en, input logic [3:0] s, input int len);
    logic [8:0] w;
    w = {1'b1, a, en, s};
    open_frame(1'b1);
    for (int i = 0; i < len; i++) sbit(i < 8 ? w[7-i] : 1'b0);
    close_frame();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset state");

    send_chain(make_frame(1));
    expect_now("R3 outputs held before configure");
    pulse_cfg();
    expect_now("R2 chain frame 1 applied, R9 dout");

    send_chain(make_frame(2));
    expect_now("R9 dout carries tail of frame 1");
    pulse_cfg();
    expect_now("R2 chain frame 2 applied");

    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sdin = 1'b1; sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; repeat (2) @(negedge clk);
    end
    pulse_cfg();
    expect_now("R4 activity with select high ignored, R8");

    send_addr(3'd5, 1'b1, 4'd9, 8);
    expect_now("R3 addressed load held");
    pulse_cfg();
    expect_now("R6 addressed output 5 only");

    mode = 1'b1; sclk = 1'b1; repeat (2) @(negedge clk);
    cs_n = 1'b0; repeat (2) @(negedge clk);
    sclk = 1'b0; repeat (2) @(negedge clk);
    cur_addr = 1'b1; nbits = 0;
    begin
      logic [7:0] w;
      w = {3'd2, 1'b0, 4'd4};
      for (int i = 7; i >= 0; i--) sbit(w[i]);
    end
    close_frame();
    pulse_cfg();
    expect_now("R5 early falling edge takes no bit");

    send_addr(3'd1, 1'b1, 4'd15, 7);
    send_addr(3'd6, 1'b1, 4'd3, 9);
    pulse_cfg();
    expect_now("R7 short and long frames discarded, R8");

    open_frame(1'b0);
    begin
      logic [39:0] f;
      f = make_frame(7);
      for (int i = 39; i >= 30; i--) sbit(f[i]);
      pulse_cfg();
      expect_now("R11 configure with select low");
      for (int i = 29; i >= 0; i--) sbit(f[i]);
    end
    close_frame();
    pulse_cfg();
    expect_now("R2 chain frame 7 applied");

    open_frame(1'b0);
    begin
      logic [39:0] f;
      f = make_frame(4);
      for (int i = 39; i >= 1; i--) sbit(f[i]);
      sdin = f[0]; sclk = 1'b1; repeat (2) @(negedge clk);
      sclk = 1'b0; cfg = 1'b1; @(negedge clk);
      cfg = 1'b0; @(negedge clk);
      m_act = m_sh; m_pend = 1'b0;
      m_dout = m_sh[39]; m_sh = {m_sh[38:0], f[0]}; m_pend = 1'b1;
      expect_now("R10 same-cycle copy takes pre-shift shadow");
    end
    close_frame();
    pulse_cfg();
    expect_now("R10 pending bit copied by next strobe");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule